// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Each source has a pending bit, an enable bit, a type bit and a 4-bit priority. The type bit sends a source to the fast line; a cleared type bit leaves it on the normal line. A 5-bit priority mask gates the normal line. A mask of all ones turns the gating off.

Software reaches the state through a word-addressed read/write port. Reads are combinational from the current address. Writes take effect at the clock edge on which the write strobe is high. Two vector registers give the winning enabled, pending source of each class together with its priority. A handler can read one of them and dispatch without scanning the pending words. Both request lines are registered.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset both request lines are low. Pending, enable, type, control and every priority read as zero, and the mask reads 31.
- R2: The fast line is high exactly when, one clock earlier, some source was pending, enabled and had its type bit set to 1.
- R3: The normal line is computed from the state one clock earlier. A candidate is a source that is pending, enabled and of type 0. With no candidate the normal line is low. With at least one candidate and a mask of 31, it is high.
- R4: With a mask other than 31, the normal line is high only if some candidate has a priority strictly greater than the mask. Masks 16 to 30 therefore block every normal source.
- R5: Each priority word holds eight 4-bit fields. Field n of slot s (bits 4n+3..4n) belongs to source 8s+n. The word at address 32+k holds slot 15-k. Slot 0 (sources 0..7) is at address 47 and slot 7 is at address 40. Addresses 32..39 read zero and ignore writes.
- R6: Writing a value v to address 2 sets enable bit v, and writing v to address 3 clears it. Values of 64 or more leave the enables unchanged.
- R7: Enable words sit at addresses 4 and 5, and type words at 6 and 7. The high word (the even address) holds sources 63..32 and the low word holds sources 31..0. Writes replace the whole half, and reads return it.
- R8: Writing address 12 or 13 overwrites the high or low half of the pending vector. A change in a source input's level copies the new level into that source's pending bit at the next edge.
- R9: The following addresses are read-only, and writes to them change nothing:
  - source words 10 and 11, which read the pending vector;
  - normal pending words 14 and 15, which read pending & enable & ~type;
  - fast pending words 16 and 17, which read pending & enable & type;
  - vector registers 8 and 9.
- R10: The mask register (address 1) keeps only bits 4..0 of a write. The control register (address 0) keeps only bits 5..0.
- R11: The normal vector (address 8) and the fast vector (address 9) each cover their own candidate class. Each returns the source number in bits 31..16 and its priority in bits 15..0. The source with the highest priority wins, and ties go to the higher source number. With no candidate the register reads 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 64 | Source request levels |
| bus_addr | input | 6 | Word address for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| req_norm_o | output | 1 | Registered normal interrupt request |
| req_fast_o | output | 1 | Registered fast interrupt request |

## Verification
The hardest condition to reach from the ports is the boundary of the mask comparison. It needs a single normal candidate whose priority sits exactly at, just above or just below the mask. This is reached by forcing all pending bits high and enabling one source by number. The bench then rewrites that source's priority field and the mask over all 16 × 32 combinations. The priority layout is reversed across the addresses, which is easy to get wrong. It is covered by enabling each of the 64 sources alone under a distinct priority pattern and reading the normal vector back.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int unsigned NUM_SRC   = 64;
  localparam int unsigned PRIO_W    = 4;
  localparam int unsigned MASK_W    = 5;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 6;
  localparam int unsigned PRIO_REGS = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'd0;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'd1;
  localparam logic [ADDR_W-1:0] A_ENSET  = 6'd2;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 6'd3;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 6'd4;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 6'd5;
  localparam logic [ADDR_W-1:0] A_TY_HI  = 6'd6;
  localparam logic [ADDR_W-1:0] A_TY_LO  = 6'd7;
  localparam logic [ADDR_W-1:0] A_NVEC   = 6'd8;
  localparam logic [ADDR_W-1:0] A_FVEC   = 6'd9;
  localparam logic [ADDR_W-1:0] A_SRC_HI = 6'd10;
  localparam logic [ADDR_W-1:0] A_SRC_LO = 6'd11;
  localparam logic [ADDR_W-1:0] A_FRC_HI = 6'd12;
  localparam logic [ADDR_W-1:0] A_FRC_LO = 6'd13;
  localparam logic [ADDR_W-1:0] A_NP_HI  = 6'd14;
  localparam logic [ADDR_W-1:0] A_NP_LO  = 6'd15;
  localparam logic [ADDR_W-1:0] A_FP_HI  = 6'd16;
  localparam logic [ADDR_W-1:0] A_FP_LO  = 6'd17;
  localparam logic [ADDR_W-1:0] A_PRIO   = 6'd32;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0000_003F;
endpackage

// File: rtl/vpic_rstsync.sv
module vpic_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/vpic_regfile.sv
module vpic_regfile
  import vpic_pkg::*;
#(
  parameter int unsigned N     = NUM_SRC,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned MW    = MASK_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned PREGS = PRIO_REGS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    src_i,
  input  logic [AW-1:0]   addr,
  input  logic            wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   ctrl_o,
  output logic [MW-1:0]   mask_o,
  output logic [N-1:0]    en_o,
  output logic [N-1:0]    typ_o,
  output logic [N-1:0]    pend_o,
  output logic [N*PW-1:0] prio_o
);
  localparam int unsigned HALF    = N / 2;
  localparam int unsigned PER_REG = DW / PW;
  localparam int unsigned SLOTS   = N / PER_REG;
  localparam int unsigned IW      = $clog2(N);

  logic [DW-1:0] ctrl_q, ctrl_d;
  logic [MW-1:0] mask_q, mask_d;
  logic [N-1:0]  en_q, en_d;
  logic [N-1:0]  typ_q, typ_d;
  logic [N-1:0]  pend_q, pend_d;
  logic [N-1:0]  src_q;
  logic [DW-1:0] prio_q [SLOTS];
  logic [DW-1:0] prio_d [SLOTS];

  // next-state logic
  always_comb begin
    ctrl_d = ctrl_q;
    mask_d = mask_q;
    en_d   = en_q;
    typ_d  = typ_q;
    pend_d = pend_q;
    for (int s = 0; s < SLOTS; s++) prio_d[s] = prio_q[s];

    for (int i = 0; i < N; i++) begin
      if (src_i[i] != src_q[i]) pend_d[i] = src_i[i];
    end

    if (wr) begin
      case (addr)
        A_CTRL:   ctrl_d = wdata & CTRL_KEEP;
        A_MASK:   mask_d = wdata[MW-1:0];
        A_ENSET:  if (wdata < DW'(N)) en_d[wdata[IW-1:0]] = 1'b1;
        A_ENCLR:  if (wdata < DW'(N)) en_d[wdata[IW-1:0]] = 1'b0;
        A_EN_HI:  en_d[N-1:HALF]   = wdata[HALF-1:0];
        A_EN_LO:  en_d[HALF-1:0]   = wdata[HALF-1:0];
        A_TY_HI:  typ_d[N-1:HALF]  = wdata[HALF-1:0];
        A_TY_LO:  typ_d[HALF-1:0]  = wdata[HALF-1:0];
        A_FRC_HI: pend_d[N-1:HALF] = wdata[HALF-1:0];
        A_FRC_LO: pend_d[HALF-1:0] = wdata[HALF-1:0];
        default: begin
          for (int s = 0; s < SLOTS; s++) begin
            if (addr == AW'(int'(A_PRIO) + int'(PREGS) - 1 - s)) prio_d[s] = wdata;
          end
        end
      endcase
    end
  end

  // configuration registers, written only under the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '1;
      en_q   <= '0;
      typ_q  <= '0;
      for (int s = 0; s < SLOTS; s++) prio_q[s] <= '0;
    end else if (wr) begin
      ctrl_q <= ctrl_d;
      mask_q <= mask_d;
      en_q   <= en_d;
      typ_q  <= typ_d;
      for (int s = 0; s < SLOTS; s++) prio_q[s] <= prio_d[s];
    end
  end

  // pending state and sampled source levels, updated every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      src_q  <= '0;
    end else begin
      pend_q <= pend_d;
      src_q  <= src_i;
    end
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign en_o   = en_q;
  assign typ_o  = typ_q;
  assign pend_o = pend_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_prio_flat
    assign prio_o[g*DW +: DW] = prio_q[g];
  end
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
  parameter int unsigned N  = 64,
  parameter int unsigned PW = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]    cand,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  // ascending scan with >=, so the higher index wins a tie
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || (prio[i*PW +: PW] >= best))) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = prio[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/vpic_outstage.sv
module vpic_outstage #(
  parameter int unsigned PW = 4,
  parameter int unsigned MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          any_norm,
  input  logic [PW-1:0] norm_best,
  input  logic [MW-1:0] mask,
  input  logic          any_fast,
  output logic          req_norm_o,
  output logic          req_fast_o
);
  logic norm_d, fast_d;

  always_comb begin
    fast_d = any_fast;
    norm_d = any_norm && ((mask == {MW{1'b1}}) || (MW'(norm_best) > mask));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_norm_o <= 1'b0;
      req_fast_o <= 1'b0;
    end else begin
      req_norm_o <= norm_d;
      req_fast_o <= fast_d;
    end
  end
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int unsigned N     = NUM_SRC,
  parameter int unsigned PW    = PRIO_W,
  parameter int unsigned MW    = MASK_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned PREGS = PRIO_REGS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          req_norm_o,
  output logic          req_fast_o
);
  localparam int unsigned HALF  = N / 2;
  localparam int unsigned VH    = DW / 2;
  localparam int unsigned IW    = $clog2(N);
  localparam int unsigned SLOTS = N * PW / DW;

  logic            rst_sync_n;
  logic [DW-1:0]   ctrl_w;
  logic [MW-1:0]   mask_w;
  logic [N-1:0]    en_w, typ_w, pend_w;
  logic [N*PW-1:0] prio_w;
  logic [N-1:0]    cand   [2];
  logic            found  [2];
  logic [IW-1:0]   win_idx[2];
  logic [PW-1:0]   win_pri[2];
  logic [DW-1:0]   vec    [2];

  vpic_rstsync #(.STAGES(2)) i_rstsync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  vpic_regfile #(.N(N), .PW(PW), .MW(MW), .DW(DW), .AW(AW), .PREGS(PREGS)) i_regfile (
    .clk(clk), .rst_n(rst_sync_n), .src_i(src_i), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .ctrl_o(ctrl_w), .mask_o(mask_w), .en_o(en_w), .typ_o(typ_w),
    .pend_o(pend_w), .prio_o(prio_w)
  );

  assign cand[0] = pend_w & en_w & ~typ_w;
  assign cand[1] = pend_w & en_w & typ_w;

  // class 0 is the normal line, class 1 the fast line
  for (genvar g = 0; g < 2; g++) begin : g_class
    vpic_arbiter #(.N(N), .PW(PW)) i_arbiter (
      .cand(cand[g]), .prio(prio_w), .found(found[g]), .idx(win_idx[g]), .best(win_pri[g])
    );
    assign vec[g] = found[g] ? {VH'(win_idx[g]), VH'(win_pri[g])} : '1;
  end

  vpic_outstage #(.PW(PW), .MW(MW)) i_outstage (
    .clk(clk), .rst_n(rst_sync_n), .any_norm(|cand[0]), .norm_best(win_pri[0]),
    .mask(mask_w), .any_fast(|cand[1]), .req_norm_o(req_norm_o), .req_fast_o(req_fast_o)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_w;
      A_MASK:   bus_rdata = DW'(mask_w);
      A_EN_HI:  bus_rdata = DW'(en_w[N-1:HALF]);
      A_EN_LO:  bus_rdata = DW'(en_w[HALF-1:0]);
      A_TY_HI:  bus_rdata = DW'(typ_w[N-1:HALF]);
      A_TY_LO:  bus_rdata = DW'(typ_w[HALF-1:0]);
      A_NVEC:   bus_rdata = vec[0];
      A_FVEC:   bus_rdata = vec[1];
      A_SRC_HI, A_FRC_HI: bus_rdata = DW'(pend_w[N-1:HALF]);
      A_SRC_LO, A_FRC_LO: bus_rdata = DW'(pend_w[HALF-1:0]);
      A_NP_HI:  bus_rdata = DW'(cand[0][N-1:HALF]);
      A_NP_LO:  bus_rdata = DW'(cand[0][HALF-1:0]);
      A_FP_HI:  bus_rdata = DW'(cand[1][N-1:HALF]);
      A_FP_LO:  bus_rdata = DW'(cand[1][HALF-1:0]);
      default: begin
        for (int s = 0; s < SLOTS; s++) begin
          if (bus_addr == AW'(int'(A_PRIO) + int'(PREGS) - 1 - s))
            bus_rdata = prio_w[s*DW +: DW];
        end
      end
    endcase
  end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              req_norm_o,
  input logic              req_fast_o,
  input logic [MASK_W-1:0] mask,
  input logic [NUM_SRC-1:0] en,
  input logic [NUM_SRC-1:0] typ,
  input logic [NUM_SRC-1:0] pend
);
  logic [NUM_SRC-1:0] cn, cf;
  assign cn = pend & en & ~typ;
  assign cf = pend & en & typ;

  p_fast_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_fast_o == $past(|cf));

  p_norm_needs_cand_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_norm_o |-> $past(|cn));

  p_norm_open_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask) == {MASK_W{1'b1}} && $past(|cn)) |-> req_norm_o);

  p_norm_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask) >= 5'd16 && $past(mask) != {MASK_W{1'b1}}) |-> !req_norm_o);

  p_mask_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> (mask == $past(bus_wdata[MASK_W-1:0])));

  p_enset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENSET && bus_wdata < 32'd64) |=> en[$past(bus_wdata[5:0])]);

  p_enclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENCLR && bus_wdata < 32'd64) |=> !en[$past(bus_wdata[5:0])]);

  p_nvec_hit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_NVEC && bus_rdata != '1) |-> cn[bus_rdata[21:16]]);
endmodule

bind vpic_ctrl vpic_checker i_vpic_checker (
  .clk(clk), .rst_n(rst_sync_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_norm_o(req_norm_o),
  .req_fast_o(req_fast_o), .mask(mask_w), .en(en_w), .typ(typ_w), .pend(pend_w)
);

// File: tb/test_vpic_ctrl.sv
module test_vpic_ctrl;
  import vpic_pkg::*;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_i;
  logic [5:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        req_norm_o, req_fast_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] en_m, ty_m, pend_m;
  logic [3:0]  prio_m [64];
  logic [4:0]  mask_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpic_ctrl i_vpic_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_norm_o(req_norm_o),
    .req_fast_o(req_fast_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [31:0] vec_m(input logic [63:0] c);
    int best = -1;
    int idx = -1;
    for (int i = 63; i >= 0; i--) begin
      if (c[i] && int'(prio_m[i]) > best) begin
        best = int'(prio_m[i]);
        idx = i;
      end
    end
    return (idx < 0) ? 32'hFFFF_FFFF : {16'(idx), 16'(best)};
  endfunction

  function automatic logic nreq_m();
    logic [63:0] c = pend_m & en_m & ~ty_m;
    if (c == 0) return 1'b0;
    if (mask_m == 5'd31) return 1'b1;
    for (int i = 0; i < 64; i++) if (c[i] && {1'b0, prio_m[i]} > mask_m) return 1'b1;
    return 1'b0;
  endfunction

  task automatic write_prio_slot(input int s);
    logic [31:0] w = '0;
    for (int n = 0; n < 8; n++) w[4*n +: 4] = prio_m[8*s+n];
    wr(6'(32 + 15 - s), w);
  endtask

  task automatic check_state(input string tag);
    logic [31:0] d;
    tick();
    chk({tag, " R3 R4 normal line"}, {31'd0, req_norm_o}, {31'd0, nreq_m()});
    chk({tag, " R2 fast line"}, {31'd0, req_fast_o}, {31'd0, |(pend_m & en_m & ty_m)});
    rd(A_NVEC, d); chk({tag, " R11 normal vector"}, d, vec_m(pend_m & en_m & ~ty_m));
    rd(A_FVEC, d); chk({tag, " R11 fast vector"}, d, vec_m(pend_m & en_m & ty_m));
    rd(A_NP_LO, d); chk({tag, " R9 normal pending"}, d, (pend_m & en_m & ~ty_m) & 64'hFFFF_FFFF);
    rd(A_FP_HI, d); chk({tag, " R9 fast pending"}, d, 32'((pend_m & en_m & ty_m) >> 32));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; src_i = '0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    en_m = '0; ty_m = '0; pend_m = '0; mask_m = 5'd31;
    for (int i = 0; i < 64; i++) prio_m[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 normal line", {31'd0, req_norm_o}, 32'd0);
    chk("R1 fast line", {31'd0, req_fast_o}, 32'd0);
    rd(A_CTRL, d);  chk("R1 control", d, 32'd0);
    rd(A_MASK, d);  chk("R1 mask", d, 32'd31);
    rd(A_EN_HI, d); chk("R1 enable hi", d, 32'd0);
    rd(A_TY_LO, d); chk("R1 type lo", d, 32'd0);
    rd(A_SRC_LO, d); chk("R1 pending lo", d, 32'd0);
    for (int a = 32; a < 48; a++) begin
      rd(6'(a), d); chk("R1 priority", d, 32'd0);
    end
    rd(A_NVEC, d); chk("R1 R11 empty vector", d, 32'hFFFF_FFFF);

    // R10 field masking
    wr(A_MASK, 32'hFFFF_FFE3); rd(A_MASK, d); chk("R10 mask bits", d, 32'd3);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R10 control bits", d, 32'h3F);
    wr(A_MASK, 32'd31);

    // R5 priority address map and unimplemented words
    for (int a = 32; a < 48; a++) wr(6'(a), 32'h1357_9BDF ^ (32'(a) * 32'h0101_0101));
    for (int a = 32; a < 48; a++) begin
      rd(6'(a), d);
      chk("R5 priority readback", d, (a < 40) ? 32'd0 : (32'h1357_9BDF ^ (32'(a) * 32'h0101_0101)));
    end

    // R5 R6 R11: each source alone, distinct priorities
    for (int i = 0; i < 64; i++) prio_m[i] = 4'((i * 5 + 2) % 16);
    for (int s = 0; s < 8; s++) write_prio_slot(s);
    wr(A_FRC_HI, 32'hFFFF_FFFF); wr(A_FRC_LO, 32'hFFFF_FFFF); pend_m = '1;
    for (int j = 0; j < 64; j++) begin
      wr(A_EN_HI, 32'd0); wr(A_EN_LO, 32'd0);
      wr(A_ENSET, 32'(j));
      en_m = 64'd1 << j;
      rd(A_NVEC, d); chk("R5 R6 single source vector", d, {16'(j), 16'(prio_m[j])});
    end
    check_state("single");

    // R6 out-of-range numbers ignored, then clear by number
    wr(A_ENSET, 32'd64); wr(A_ENCLR, 32'd70); wr(A_ENSET, 32'hFFFF_FFFF);
    rd(A_EN_HI, d); chk("R6 ignored high", d, 32'h8000_0000);
    rd(A_EN_LO, d); chk("R6 ignored low", d, 32'd0);
    wr(A_ENCLR, 32'd63); en_m = '0;
    rd(A_EN_HI, d); chk("R6 clear by number", d, 32'd0);
    check_state("none enabled");

    // R7 half words
    wr(A_EN_HI, 32'hA5A5_0000); wr(A_EN_LO, 32'h0000_5A5A); en_m = 64'hA5A5_0000_0000_5A5A;
    wr(A_TY_HI, 32'h0000_0001); ty_m = 64'h0000_0001_0000_0000;
    rd(A_EN_HI, d); chk("R7 enable hi", d, 32'hA5A5_0000);
    rd(A_EN_LO, d); chk("R7 enable lo", d, 32'h0000_5A5A);
    rd(A_TY_HI, d); chk("R7 type hi", d, 32'h0000_0001);
    rd(A_TY_LO, d); chk("R7 type lo", d, 32'd0);
    check_state("mixed");

    // R2 fast class alone
    wr(A_TY_LO, 32'h0000_0010); ty_m[31:0] = 32'h10;
    wr(A_EN_LO, 32'h0000_5A5A | 32'h10); en_m[31:0] = 32'h5A5A | 32'h10;
    check_state("fast source 4");

    // R9 writes to read-only registers ignored
    wr(A_NP_LO, 32'd0); wr(A_FP_HI, 32'hFFFF_FFFF); wr(A_SRC_LO, 32'd0);
    wr(A_NVEC, 32'd0); wr(A_FVEC, 32'd0);
    rd(A_SRC_LO, d); chk("R9 source word unchanged", d, 32'hFFFF_FFFF);
    check_state("readonly writes");

    // R11 ties go to the higher number
    for (int i = 0; i < 64; i++) prio_m[i] = 4'd7;
    for (int s = 0; s < 8; s++) write_prio_slot(s);
    wr(A_TY_HI, 32'd0); wr(A_TY_LO, 32'd0); ty_m = '0;
    wr(A_EN_HI, 32'hFFFF_FFFF); wr(A_EN_LO, 32'hFFFF_FFFF); en_m = '1;
    rd(A_NVEC, d); chk("R11 tie to source 63", d, {16'd63, 16'd7});
    wr(A_FRC_HI, 32'h7FFF_FFFF); pend_m[63] = 1'b0;
    rd(A_NVEC, d); chk("R11 tie to source 62", d, {16'd62, 16'd7});
    check_state("ties");

    // R3 R4 mask sweep with a single normal candidate, source 10
    wr(A_FRC_HI, 32'd0); wr(A_FRC_LO, 32'h0000_0400); pend_m = 64'h400;
    for (int i = 8; i < 16; i++) prio_m[i] = '0;
    for (int p = 0; p < 16; p++) begin
      prio_m[10] = 4'(p);
      write_prio_slot(1);
      for (int m = 0; m < 32; m++) begin
        wr(A_MASK, 32'(m)); mask_m = 5'(m);
        tick();
        chk("R3 R4 mask sweep", {31'd0, req_norm_o}, {31'd0, (m == 31) || (p > m)});
      end
    end
    wr(A_FRC_LO, 32'd0); pend_m = '0; wr(A_MASK, 32'd5); mask_m = 5'd5;
    tick();
    chk("R3 no candidate", {31'd0, req_norm_o}, 32'd0);
    wr(A_MASK, 32'd31); mask_m = 5'd31;

    // R8 source levels and force
    @(negedge clk); src_i[37] = 1'b1;
    @(negedge clk);
    rd(A_SRC_HI, d); chk("R8 source rise sets pending", d, 32'h20);
    pend_m[37] = 1'b1;
    tick();
    chk("R8 normal line from source", {31'd0, req_norm_o}, {31'd0, nreq_m()});
    @(negedge clk); src_i[37] = 1'b0;
    @(negedge clk);
    rd(A_SRC_HI, d); chk("R8 source fall clears pending", d, 32'd0);
    pend_m[37] = 1'b0;
    wr(A_FRC_LO, 32'h0000_1234); pend_m[31:0] = 32'h1234;
    rd(A_SRC_LO, d); chk("R8 force low half", d, 32'h0000_1234);
    check_state("forced");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule